// File: doc/BRIEF.md
# Write-Once Security Lock Latch

This block wraps a modelled 32-bit nonvolatile write-once word with the control logic that decides whether the device is locked against external access. Software or a programmer first places a candidate word in a volatile staging register. A program strobe then copies it into the nonvolatile array, and an erase strobe clears that array. A comparator counts how many stored bits agree with a fixed key. It reports a match when that count reaches a threshold, which defaults to 28.

The comparator result is captured only once, in the first clock cycle after reset is released. The captured value becomes the lock state and holds until the next reset. While the device is locked, the debug, trace, test and programming enables stay low. Program and erase requests are then discarded, and each such attempt sets a sticky error flag. Until the capture cycle has run, the block reports itself locked and keeps every enable low. The nonvolatile array is never cleared by reset.

Top module: `wol_lock_ctrl`

## Requirements
- R1: `key_match_o` is 1 exactly when at least 28 of the 32 stored bits equal the key 32'h5053_6F43, bit for bit. It follows the stored word combinationally.
- R2: A stored word with 27 or fewer agreeing bits leaves `locked_o` at 0 after reset.
- R3: A pulse on `load_i` captures `wdata_i` into the staging register. While the device is unlocked and ready, `prog_i` copies the staging register into the array on the next clock edge. Under the same condition, `erase_i` clears the array to all zeros, and erase takes precedence over program.
- R4: From reset until the first clock edge after `rst_ni` rises, `ready_o` is 0, `locked_o` is 1 and all enables are 0. On that edge `ready_o` becomes 1 and `locked_o` takes the comparator value.
- R5: Changing the array between resets does not alter `locked_o` or the enables.
- R6: When ready and unlocked, all four enables (`dbg_en_o`, `trace_en_o`, `test_en_o`, `prog_en_o`) are 1. When locked, all four are 0.
- R7: While locked, `prog_i` and `erase_i` leave the array unchanged, so the lock survives every later reset.
- R8: `lock_err_o` becomes 1 on the edge after a program or erase request made while ready and locked. It stays 1 until reset, and it is never 1 while unlocked.
- R9: The array content is preserved across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wdata_i | input | 32 | Candidate word for the staging register |
| load_i | input | 1 | Load staging register from `wdata_i` |
| prog_i | input | 1 | Copy staging register into nonvolatile array |
| erase_i | input | 1 | Clear nonvolatile array |
| locked_o | output | 1 | Captured lock state |
| ready_o | output | 1 | Lock state has been captured since reset |
| key_match_o | output | 1 | Live super-majority comparator result |
| dbg_en_o | output | 1 | Debug access enable |
| trace_en_o | output | 1 | Trace access enable |
| test_en_o | output | 1 | Test access enable |
| prog_en_o | output | 1 | Programming access enable |
| lock_err_o | output | 1 | Sticky flag for a modify attempt while locked |

## Verification
The assertions assume that `rst_ni` is held low across at least one rising clock edge. They also assume that the strobes are driven to known values once reset is released, so that the capture cycle and the stability checks observe defined data. The stimulus changes every input on the falling clock edge. It holds reset for two full cycles and releases it on a falling edge. Strobes are raised for one cycle at a time, including the attempts made while locked. A comparator result of 1 is allowed to reach a reset only in the final lock sequence, because a lock cannot be undone.

// File: rtl/wol_pkg.sv
package wol_pkg;
  localparam int unsigned WOL_W         = 32;
  localparam logic [WOL_W-1:0] WOL_KEY  = 32'h5053_6F43;
  localparam int unsigned WOL_MATCH_MIN = 28;

  typedef struct packed {
    logic dbg;
    logic trace;
    logic test;
    logic prog;
  } access_t;
endpackage

// File: rtl/wol_shadow_reg.sv
module wol_shadow_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= wdata_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/wol_nv_array.sv
module wol_nv_array #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         prog_i,
  input  logic         erase_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  // no reset: models cells that keep their value through a device reset
  logic [W-1:0] cells_q;

  always_ff @(posedge clk_i) begin
    if (erase_i)     cells_q <= '0;
    else if (prog_i) cells_q <= wdata_i;
  end

  assign q_o = cells_q;
endmodule

// File: rtl/wol_match.sv
module wol_match #(
  parameter int unsigned    W         = 32,
  parameter logic [W-1:0]   KEY       = '0,
  parameter int unsigned    MATCH_MIN = 28
) (
  input  logic [W-1:0] word_i,
  output logic         hit_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [W-1:0]     agree;
  logic [CNT_W-1:0] cnt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign agree[i] = ~(word_i[i] ^ KEY[i]);
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CNT_W'(agree[i]);
  end

  assign hit_o = (cnt >= CNT_W'(MATCH_MIN));
endmodule

// File: rtl/wol_lock_fsm.sv
module wol_lock_fsm
  import wol_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    hit_i,
  input  logic    prog_req_i,
  input  logic    erase_req_i,
  output logic    prog_ok_o,
  output logic    erase_ok_o,
  output logic    locked_o,
  output logic    ready_o,
  output logic    err_o,
  output access_t access_o
);
  logic lock_q, done_q, err_q;
  logic modify_req;

  assign modify_req = prog_req_i | erase_req_i;

  // lock resets to 1: access stays closed until the capture cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (!done_q) begin
        done_q <= 1'b1;
        lock_q <= hit_i;
      end
      if (done_q && lock_q && modify_req) err_q <= 1'b1;
    end
  end

  assign prog_ok_o  = prog_req_i  & done_q & ~lock_q;
  assign erase_ok_o = erase_req_i & done_q & ~lock_q;

  always_comb begin
    access_o = '0;
    if (done_q && !lock_q) access_o = '{dbg: 1'b1, trace: 1'b1, test: 1'b1, prog: 1'b1};
  end

  assign locked_o = lock_q;
  assign ready_o  = done_q;
  assign err_o    = err_q;
endmodule

// File: rtl/wol_lock_ctrl.sv
module wol_lock_ctrl
  import wol_pkg::*;
#(
  parameter int unsigned  W         = WOL_W,
  parameter logic [W-1:0] KEY       = WOL_KEY,
  parameter int unsigned  MATCH_MIN = WOL_MATCH_MIN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  input  logic         prog_i,
  input  logic         erase_i,
  output logic         locked_o,
  output logic         ready_o,
  output logic         key_match_o,
  output logic         dbg_en_o,
  output logic         trace_en_o,
  output logic         test_en_o,
  output logic         prog_en_o,
  output logic         lock_err_o
);
  logic [W-1:0] stage_q;
  logic [W-1:0] nv_q;
  logic         hit;
  logic         prog_ok, erase_ok;
  access_t      access;

  wol_shadow_reg #(.W(W)) i_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .wdata_i(wdata_i),
    .q_o    (stage_q)
  );

  wol_nv_array #(.W(W)) i_nv (
    .clk_i  (clk_i),
    .prog_i (prog_ok),
    .erase_i(erase_ok),
    .wdata_i(stage_q),
    .q_o    (nv_q)
  );

  wol_match #(.W(W), .KEY(KEY), .MATCH_MIN(MATCH_MIN)) i_match (
    .word_i(nv_q),
    .hit_o (hit)
  );

  wol_lock_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .prog_req_i (prog_i),
    .erase_req_i(erase_i),
    .prog_ok_o  (prog_ok),
    .erase_ok_o (erase_ok),
    .locked_o   (locked_o),
    .ready_o    (ready_o),
    .err_o      (lock_err_o),
    .access_o   (access)
  );

  assign key_match_o = hit;
  assign dbg_en_o    = access.dbg;
  assign trace_en_o  = access.trace;
  assign test_en_o   = access.test;
  assign prog_en_o   = access.prog;
endmodule

// File: rtl/wol_lock_chk.sv
module wol_lock_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic prog_i,
  input logic erase_i,
  input logic locked_o,
  input logic ready_o,
  input logic key_match_o,
  input logic dbg_en_o,
  input logic trace_en_o,
  input logic test_en_o,
  input logic prog_en_o,
  input logic lock_err_o
);
  logic any_en;
  assign any_en = dbg_en_o | trace_en_o | test_en_o | prog_en_o;

  a_r4_fail_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (locked_o && !any_en));

  a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (locked_o == $past(key_match_o)));

  a_r5_lock_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |-> $stable(locked_o));

  a_r6_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> !any_en);

  a_r6_gate_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !locked_o) |-> (dbg_en_o && trace_en_o && test_en_o && prog_en_o));

  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && locked_o) |=> $stable(key_match_o));

  a_r8_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && locked_o && (prog_i || erase_i)) |=> lock_err_o);

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_err_o |=> lock_err_o);

  a_r8_no_err_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> !lock_err_o);
endmodule

bind wol_lock_ctrl wol_lock_chk i_wol_lock_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .prog_i     (prog_i),
  .erase_i    (erase_i),
  .locked_o   (locked_o),
  .ready_o    (ready_o),
  .key_match_o(key_match_o),
  .dbg_en_o   (dbg_en_o),
  .trace_en_o (trace_en_o),
  .test_en_o  (test_en_o),
  .prog_en_o  (prog_en_o),
  .lock_err_o (lock_err_o)
);

// File: tb/test_wol_lock_ctrl.sv
`timescale 1ns/1ps
module test_wol_lock_ctrl;
  localparam logic [31:0] K = 32'h5053_6F43;
  localparam int NV = 7;
  // word under test, expected comparator result (agreeing bits in comment)
  localparam logic [31:0] VEC_W [NV] = '{
    K,                   // 32
    K ^ 32'h0000_000F,   // 28
    K ^ 32'h0000_001F,   // 27
    ~K,                  // 0
    K ^ 32'h8000_0001,   // 30
    K ^ 32'h000F_0100,   // 27
    K ^ 32'h0000_0007    // 29
  };
  localparam logic VEC_M [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] wdata = '0;
  logic load = 1'b0, prog = 1'b0, erase = 1'b0;
  logic locked, ready, key_match, dbg_en, trace_en, test_en, prog_en, lock_err;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  wol_lock_ctrl i_wol_lock_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .wdata_i(wdata), .load_i(load),
    .prog_i(prog), .erase_i(erase), .locked_o(locked), .ready_o(ready),
    .key_match_o(key_match), .dbg_en_o(dbg_en), .trace_en_o(trace_en),
    .test_en_o(test_en), .prog_en_o(prog_en), .lock_err_o(lock_err)
  );

  function automatic logic exp_match(input logic [31:0] w);
    return $countones(~(w ^ K)) >= 28;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ens();
    return {dbg_en, trace_en, test_en, prog_en};
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk) wdata = w; load = 1'b1;
    @(negedge clk) load = 1'b0; prog = 1'b1;
    @(negedge clk) prog = 1'b0;
  endtask

  task automatic do_erase();
    @(negedge clk) erase = 1'b1;
    @(negedge clk) erase = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    // R4: fail-safe state while held in reset
    repeat (2) @(negedge clk);
    chk("R4 locked in reset", 32'(locked), 32'd1);
    chk("R4 ready in reset", 32'(ready), 32'd0);
    chk("R4 enables in reset", 32'(ens()), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R4 ready after release", 32'(ready), 32'd1);
    chk("R6 enables follow lock", 32'(ens()), locked ? 32'h0 : 32'hF);

    // R3: erase clears arbitrary initial content
    do_erase();
    chk("R3 erase gives zero word", 32'(key_match), 32'(exp_match('0)));
    do_reset();
    chk("R2 unlocked after erase", 32'(locked), 32'd0);
    chk("R6 all enables on", 32'(ens()), 32'hF);

    for (int i = 0; i < NV; i++) begin
      write_word(VEC_W[i]);
      chk("R1 comparator vector", 32'(key_match), 32'(VEC_M[i]));
      chk("R5 no lock before reset", 32'(locked), 32'd0);
      chk("R5 enables kept", 32'(ens()), 32'hF);
      if (!VEC_M[i]) begin
        do_reset();
        chk("R2 below threshold unlocked", 32'(locked), 32'd0);
        chk("R9 array kept over reset", 32'(key_match), 32'(VEC_M[i]));
      end
    end

    // random initial contents of the cells
    for (int i = 0; i < 20; i++) begin
      w = $urandom();
      if (exp_match(w)) w = w ^ 32'hFFFF_0000;
      write_word(w);
      chk("R1 random word", 32'(key_match), 32'(exp_match(w)));
      do_reset();
      chk("R2 random word unlocked", 32'(locked), 32'd0);
    end

    do_erase();
    chk("R8 no error while unlocked", 32'(lock_err), 32'd0);

    // lock with exactly 28 agreeing bits
    write_word(K ^ 32'h0F00_0000);
    chk("R1 28 bits match", 32'(key_match), 32'd1);
    chk("R5 program without reset keeps access", 32'(ens()), 32'hF);
    do_reset();
    chk("R4 lock captured", 32'(locked), 32'd1);
    chk("R6 enables off when locked", 32'(ens()), 32'h0);
    chk("R8 err clear before attempt", 32'(lock_err), 32'd0);

    write_word(32'h0);
    chk("R8 error after program attempt", 32'(lock_err), 32'd1);
    chk("R7 program ignored", 32'(key_match), 32'd1);
    do_erase();
    chk("R7 erase ignored", 32'(key_match), 32'd1);
    do_reset();
    chk("R7 still locked after reset", 32'(locked), 32'd1);
    chk("R8 error cleared by reset", 32'(lock_err), 32'd0);
    do_erase();
    chk("R8 error after erase attempt", 32'(lock_err), 32'd1);
    repeat (3) @(negedge clk);
    chk("R8 error sticky", 32'(lock_err), 32'd1);

    finish_run();
  end
endmodule